// File: doc/BRIEF.md
# Per-Channel Fault Status Latch with Interrupt

This block gathers fault reports from six measurement channels into two latched status words. One word records conversion faults, where a channel's converter has stopped producing valid results. The other records open-sensor faults, where a sensor or its leads are disconnected. Each channel has a one-cycle fault pulse input for each fault type. A set bit stays set until software reads it back, so a fault that appears only briefly is still seen.

A small register bus with separate read and write strobes gives access to both status words and to a per-channel interrupt enable word. The two status words clear on read in different ways. A read of the conversion-fault word empties the whole word. A read of the open-sensor word clears only the bits it returned as set. In both cases, a fault pulse that arrives in the same cycle as the read is kept. The single interrupt output is high while any latched conversion fault sits on an enabled channel.

Top module: `chan_fault_status`

## Requirements
- R1: After reset, both status words and the enable word are zero, `irq_o` is low and `rdata_o` is zero.
- R2: A fault pulse on channel n sets bit n-1 at the next clock edge (channels 1..6 map to bits 0..5). The bit stays set after the pulse ends, until a clearing read or reset.
- R3: A read at address 0 returns the conversion-fault word in bits 5..0 in the same cycle as the strobe. That clock edge clears every latched bit of the word.
- R4: A read at address 1 returns the open-sensor word in bits 5..0 in the same cycle. That clock edge clears only the bits returned as 1.
- R5: A fault pulse in the same cycle as a clearing read of its word is latched and is present after the read.
- R6: A write at address 2 loads bits 5..0 into the enable word, and bits 15..6 of the write data are ignored. A read at address 2 returns the enable word and changes nothing. Bits 15..6 of `rdata_o` are always zero.
- R7: `irq_o` is high exactly when some channel has both its conversion-fault bit and its enable bit set. It follows the latched state with no extra register delay.
- R8: `irq_o` falls after the edge of a clearing read of the conversion-fault word, or after a write that disables every faulted channel.
- R9: Open-sensor faults never raise `irq_o`.
- R10: Writes to address 0 or 1 have no effect on either status word.
- R11: `rdata_o` is zero when `rd_en_i` is low or when the address is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_fault_i | input | 6 | Per-channel conversion-fault pulses |
| open_fault_i | input | 6 | Per-channel open-sensor fault pulses |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address: 0 conversion status, 1 open status, 2 enable |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while `rd_en_i` is high |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational: it is valid in the cycle the strobe is high. The bench samples it one nanosecond after driving the strobe on a falling edge, before the clearing edge. Fault pulses and writes take effect at the first rising edge after they are driven. Status readback and `irq_o` are therefore checked in the following low phase, one register stage later. The effect of a clearing read is checked by a second read started on the next falling edge. This confirms that the clear happened and that any fault pulse driven together with the read survived it.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

    localparam int CFL_NCH = 6;
    localparam int CFL_DW  = 16;
    localparam int CFL_AW  = 2;

    typedef enum logic [CFL_AW-1:0] {
        REG_CONV = 2'd0,
        REG_OPEN = 2'd1,
        REG_IEN  = 2'd2,
        REG_NONE = 2'd3
    } cfl_reg_e;

endpackage

// File: rtl/cfl_status_latch.sv
module cfl_status_latch #(
    parameter int NCH     = 6,
    parameter bit CLR_ALL = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fault_i,
    input  logic           rd_i,
    output logic [NCH-1:0] q_o
);

    typedef struct packed {
        logic [NCH-1:0] bits;
    } st_t;

    st_t st_d, st_q;
    logic [NCH-1:0] clr_mask;

    generate
        if (CLR_ALL) begin : g_clr_all
            always_comb clr_mask = {NCH{rd_i}};
        end else begin : g_clr_returned
            always_comb clr_mask = rd_i ? st_q.bits : '0;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_mask) | fault_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

    assert_fault_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i != '0) |=> ((q_o & $past(fault_i)) == $past(fault_i)));

    assert_hold_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((q_o & $past(q_o)) == $past(q_o)));

    assert_read_keeps_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (q_o == $past(fault_i)));

endmodule

// File: rtl/cfl_irq_enable.sv
module cfl_irq_enable #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [NCH-1:0] wdata_i,
    output logic [NCH-1:0] en_o
);

    typedef struct packed {
        logic [NCH-1:0] en;
    } en_st_t;

    en_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.en = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    assert_en_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));

endmodule

// File: rtl/cfl_reg_decode.sv
module cfl_reg_decode
    import cfl_pkg::*;
#(
    parameter int NCH = 6,
    parameter int DW  = 16
) (
    input  logic                rd_en_i,
    input  logic                wr_en_i,
    input  logic [CFL_AW-1:0]   addr_i,
    input  logic [NCH-1:0]      conv_q_i,
    input  logic [NCH-1:0]      open_q_i,
    input  logic [NCH-1:0]      en_q_i,
    output logic                rd_conv_o,
    output logic                rd_open_o,
    output logic                wr_ien_o,
    output logic [DW-1:0]       rdata_o
);

    localparam int PAD = DW - NCH;

    cfl_reg_e sel;
    logic [NCH-1:0] rsel;

    always_comb begin
        sel       = cfl_reg_e'(addr_i);
        rd_conv_o = rd_en_i && (sel == REG_CONV);
        rd_open_o = rd_en_i && (sel == REG_OPEN);
        wr_ien_o  = wr_en_i && (sel == REG_IEN);
        rsel      = '0;
        if (rd_en_i) begin
            unique case (sel)
                REG_CONV: rsel = conv_q_i;
                REG_OPEN: rsel = open_q_i;
                REG_IEN:  rsel = en_q_i;
                REG_NONE: rsel = '0;
            endcase
        end
        rdata_o = {{PAD{1'b0}}, rsel};
    end

endmodule

// File: rtl/chan_fault_status.sv
module chan_fault_status
    import cfl_pkg::*;
#(
    parameter int NCH = CFL_NCH,
    parameter int DW  = CFL_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    conv_fault_i,
    input  logic [NCH-1:0]    open_fault_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [CFL_AW-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              irq_o
);

    logic [NCH-1:0] conv_q, open_q, en_q;
    logic rd_conv, rd_open, wr_ien;

    cfl_reg_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .rd_en_i  (rd_en_i),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .conv_q_i (conv_q),
        .open_q_i (open_q),
        .en_q_i   (en_q),
        .rd_conv_o(rd_conv),
        .rd_open_o(rd_open),
        .wr_ien_o (wr_ien),
        .rdata_o  (rdata_o)
    );

    cfl_status_latch #(.NCH(NCH), .CLR_ALL(1'b1)) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault_i(conv_fault_i),
        .rd_i   (rd_conv),
        .q_o    (conv_q)
    );

    cfl_status_latch #(.NCH(NCH), .CLR_ALL(1'b0)) u_open (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault_i(open_fault_i),
        .rd_i   (rd_open),
        .q_o    (open_q)
    );

    cfl_irq_enable #(.NCH(NCH)) u_ien (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_ien),
        .wdata_i(wdata_i[NCH-1:0]),
        .en_o   (en_q)
    );

    assign irq_o = |(conv_q & en_q);

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_q != '0) && (conv_q != '0));

    assert_rdata_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DW-1:NCH] == '0);

    assert_irq_drops_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_conv && conv_fault_i == '0) |=> !irq_o);

    assert_open_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_q == '0) |-> !irq_o);

    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> (rdata_o == '0));

endmodule

// File: tb/sim_chan_fault_status.sv
module sim_chan_fault_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  conv_fault = '0;
    logic [5:0]  open_fault = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    chan_fault_status u0 (
        .clk(clk), .rst_n(rst_n),
        .conv_fault_i(conv_fault), .open_fault_i(open_fault),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read: strobe driven at falling edge, data sampled 1 ns later, edge clears.
    task automatic rd(input logic [1:0] a, input logic [5:0] cf, input logic [5:0] of,
                      output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1; conv_fault = cf; open_fault = of;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; conv_fault = '0; open_fault = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [5:0] cf, input logic [5:0] of);
        @(negedge clk);
        conv_fault = cf; open_fault = of;
        @(negedge clk);
        conv_fault = '0; open_fault = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        #1;
        chk("R1 irq", {15'd0, irq}, 16'h0);
        chk("R1 rdata idle", rdata, 16'h0);
        rd(2'd0, '0, '0, d); chk("R1 conv", d, 16'h0);
        rd(2'd1, '0, '0, d); chk("R1 open", d, 16'h0);
        rd(2'd2, '0, '0, d); chk("R1 ien", d, 16'h0);
    endtask

    task automatic t_latch_and_clear_all();
        logic [15:0] d;
        pulse(6'b000101, '0);
        repeat (3) @(negedge clk);
        chk("R11 rdata idle", rdata, 16'h0);
        rd(2'd0, '0, '0, d); chk("R2 R3 conv latched", d, 16'h0005);
        rd(2'd0, '0, '0, d); chk("R3 conv cleared", d, 16'h0);
        pulse(6'b100000, '0);
        pulse(6'b000010, '0);
        rd(2'd0, '0, '0, d); chk("R2 conv accumulate", d, 16'h0022);
        rd(2'd0, '0, '0, d); chk("R3 conv cleared 2", d, 16'h0);
    endtask

    task automatic t_open_partial_clear();
        logic [15:0] d;
        pulse('0, 6'b001001);
        rd(2'd1, '0, 6'b010000, d); chk("R4 open returned", d, 16'h0009);
        rd(2'd1, '0, '0, d); chk("R4 R5 open kept new", d, 16'h0010);
        rd(2'd1, '0, '0, d); chk("R4 open cleared", d, 16'h0);
    endtask

    task automatic t_same_cycle();
        logic [15:0] d;
        pulse(6'b000011, '0);
        rd(2'd0, 6'b001000, '0, d); chk("R5 conv returned", d, 16'h0003);
        rd(2'd0, '0, '0, d); chk("R5 conv kept new", d, 16'h0008);
        rd(2'd0, '0, '0, d); chk("R5 conv cleared", d, 16'h0);
    endtask

    task automatic t_enable_reg();
        logic [15:0] d;
        wr(2'd2, 16'hFFEA);
        rd(2'd2, '0, '0, d); chk("R6 ien readback", d, 16'h002A);
        rd(2'd2, '0, '0, d); chk("R6 ien read no clear", d, 16'h002A);
        rd(2'd3, '0, '0, d); chk("R11 unmapped", d, 16'h0);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        wr(2'd2, 16'h0002);
        pulse(6'b000001, '0);
        #1 chk("R7 irq disabled ch", {15'd0, irq}, 16'h0);
        pulse('0, 6'b000010);
        #1 chk("R9 open no irq", {15'd0, irq}, 16'h0);
        rd(2'd1, '0, '0, d);
        @(negedge clk);
        conv_fault = 6'b000010;
        #1 chk("R7 irq not before edge", {15'd0, irq}, 16'h0);
        @(negedge clk);
        conv_fault = '0;
        #1 chk("R7 irq after edge", {15'd0, irq}, 16'h1);
        rd(2'd0, '0, '0, d); chk("R7 conv both", d, 16'h0003);
        #1 chk("R8 irq after clear", {15'd0, irq}, 16'h0);
        pulse(6'b000010, '0);
        #1 chk("R7 irq again", {15'd0, irq}, 16'h1);
        wr(2'd2, 16'h0000);
        #1 chk("R8 irq after disable", {15'd0, irq}, 16'h0);
        rd(2'd0, '0, '0, d);
    endtask

    task automatic t_status_write_ignored();
        logic [15:0] d;
        pulse(6'b000100, 6'b010000);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'hFFFF);
        rd(2'd0, '0, '0, d); chk("R10 conv unaffected", d, 16'h0004);
        rd(2'd1, '0, '0, d); chk("R10 open unaffected", d, 16'h0010);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_latch_and_clear_all();
                t_open_partial_clear();
                t_same_cycle();
                t_enable_reg();
                t_irq();
                t_status_write_ignored();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule